// File: doc/BRIEF.md
# SPI Host Interrupt and Error Aggregator

This block gathers the error and event conditions of an SPI host controller and turns them into two interrupt lines: one for errors and one for events. Single-cycle error pulses from the controller land in a sticky error status register. Level status flags (ready, idle, FIFO full/empty, watermarks) are filtered by a per-cause event enable. Each class then feeds a sticky, write-one-to-clear interrupt state bit. The state bit can also be forced through a write-only test register. Each output pin is its state bit gated by an interrupt enable bit.

Software reaches the six registers through a plain word-indexed write/read port. A write is applied on the clock edge where the write strobe is high. A read is combinational from the address.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset, interrupt state, interrupt enable, error status and event enable read 0, error enable reads 0x1F, and both interrupt outputs are low.
- R2: Word index 0 is interrupt state, 1 is interrupt enable, 2 is interrupt test, 3 is error enable, 4 is error status and 5 is event enable. Enable registers read back what was written, limited to their width (2, 5 and 6 bits). Indices 6 and 7 read zero.
- R3: An error pulse sets its error status bit on the next edge, and the bit stays set. The bit positions are: 0 command busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip-select, 5 invalid access. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: Interrupt state bit 0 sets one edge after any of status bits 0–4 is set with its error enable bit (same bit order). Status bit 5 and disabled causes never set it.
- R5: Interrupt state bit 1 sets one edge after any event level is high with its event enable bit. The event bits are: 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready, 5 idle.
- R6: Writing 1 to bit 0 or bit 1 of the test register sets the matching interrupt state bit on that edge, whatever the causes are. The force lasts only for that one write.
- R7: Writing 1 to an interrupt state bit clears it. If its cause is still true on that edge, the bit stays set.
- R8: The error output equals state bit 0 AND enable bit 0. The event output equals state bit 1 AND enable bit 1.
- R9: The test register always reads zero.
- R10: When an error pulse and a write-one-to-clear of the same status bit fall on the same edge, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| err_pulse_i | input | 6 | Single-cycle error pulses, status bit order |
| evt_level_i | input | 6 | Event condition levels, event enable bit order |
| irq_err_o | output | 1 | Error interrupt |
| irq_evt_o | output | 1 | Event interrupt |

## Verification
Two collisions are provoked on purpose. The first is an error pulse that arrives on the same edge as a software clear of the same status bit; the status register is read back afterwards and must show the bit still set. The second is a clear of the event interrupt state bit while its enabled level is still high; the state must read back still set, and must clear only once the level has dropped. Both checks are judged purely through register reads and the output pins.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned IRQ_W    = 2;  // error class, event class
  localparam int unsigned ERR_W    = 6;  // error status width
  localparam int unsigned ERR_EN_W = 5;  // maskable error causes
  localparam int unsigned EVT_W    = 6;  // event causes
  localparam int unsigned ADDR_W   = 3;

  localparam logic [ERR_EN_W-1:0] ERR_EN_RST = '1;

  typedef enum logic [ADDR_W-1:0] {
    A_STATE   = 3'd0,
    A_IRQ_EN  = 3'd1,
    A_TEST    = 3'd2,
    A_ERR_EN  = 3'd3,
    A_ERR_ST  = 3'd4,
    A_EVT_EN  = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/spi_irq_cfg.sv
// Plain read/write configuration register with a parameterised reset value.
module spi_irq_cfg #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (we_i) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST;
    else if (we_i) q_o <= q_d;
  end
endmodule

// File: rtl/spi_irq_sticky.sv
// Sticky bit vector: set dominates a write-one-to-clear on the same edge.
module spi_irq_sticky #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    q_d = (q_o & ~clr_i) | set_i;
    upd = |(set_i | clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (upd) q_o <= q_d;
  end
endmodule

// File: rtl/spi_irq_cause.sv
// Reduces masked error and event causes to one request per interrupt class.
module spi_irq_cause
  import spi_irq_pkg::*;
(
  input  logic [ERR_W-1:0]    err_status_i,
  input  logic [ERR_EN_W-1:0] err_en_i,
  input  logic [EVT_W-1:0]    evt_level_i,
  input  logic [EVT_W-1:0]    evt_en_i,
  output logic [IRQ_W-1:0]    cause_o
);
  logic [ERR_EN_W-1:0] err_hit;
  logic [EVT_W-1:0]    evt_hit;
  logic                unused_access;

  // Only the maskable causes take part; invalid access is report-only.
  assign unused_access = err_status_i[ERR_W-1];

  for (genvar i = 0; i < ERR_EN_W; i++) begin : g_err
    assign err_hit[i] = err_status_i[i] & err_en_i[i];
  end

  for (genvar j = 0; j < EVT_W; j++) begin : g_evt
    assign evt_hit[j] = evt_level_i[j] & evt_en_i[j];
  end

  assign cause_o = {|evt_hit, |err_hit};
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ERR_W-1:0]  err_pulse_i,
  input  logic [EVT_W-1:0]  evt_level_i,
  output logic              irq_err_o,
  output logic              irq_evt_o
);
  localparam int unsigned USED_W = ERR_W;

  // write decode
  logic we_state, we_irq_en, we_test, we_err_en, we_err_st, we_evt_en;
  always_comb begin
    we_state  = reg_we_i && (reg_addr_i == A_STATE);
    we_irq_en = reg_we_i && (reg_addr_i == A_IRQ_EN);
    we_test   = reg_we_i && (reg_addr_i == A_TEST);
    we_err_en = reg_we_i && (reg_addr_i == A_ERR_EN);
    we_err_st = reg_we_i && (reg_addr_i == A_ERR_ST);
    we_evt_en = reg_we_i && (reg_addr_i == A_EVT_EN);
  end

  logic [IRQ_W-1:0]    irq_en_q;
  logic [ERR_EN_W-1:0] err_en_q;
  logic [EVT_W-1:0]    evt_en_q;
  logic [ERR_W-1:0]    err_status_q;
  logic [IRQ_W-1:0]    irq_state_q;
  logic [IRQ_W-1:0]    cause;
  logic [IRQ_W-1:0]    test_set;
  logic [IRQ_W-1:0]    state_clr;
  logic [ERR_W-1:0]    err_clr;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:USED_W];

  spi_irq_cfg #(.W(IRQ_W), .RST('0)) u_irq_en (
    .clk_i, .rst_ni, .we_i(we_irq_en), .d_i(reg_wdata_i[IRQ_W-1:0]), .q_o(irq_en_q)
  );
  spi_irq_cfg #(.W(ERR_EN_W), .RST(ERR_EN_RST)) u_err_en (
    .clk_i, .rst_ni, .we_i(we_err_en), .d_i(reg_wdata_i[ERR_EN_W-1:0]), .q_o(err_en_q)
  );
  spi_irq_cfg #(.W(EVT_W), .RST('0)) u_evt_en (
    .clk_i, .rst_ni, .we_i(we_evt_en), .d_i(reg_wdata_i[EVT_W-1:0]), .q_o(evt_en_q)
  );

  assign err_clr = we_err_st ? reg_wdata_i[ERR_W-1:0] : '0;

  spi_irq_sticky #(.W(ERR_W)) u_err_st (
    .clk_i, .rst_ni, .set_i(err_pulse_i), .clr_i(err_clr), .q_o(err_status_q)
  );

  spi_irq_cause u_cause (
    .err_status_i(err_status_q), .err_en_i(err_en_q),
    .evt_level_i(evt_level_i), .evt_en_i(evt_en_q), .cause_o(cause)
  );

  assign test_set  = we_test  ? reg_wdata_i[IRQ_W-1:0] : '0;
  assign state_clr = we_state ? reg_wdata_i[IRQ_W-1:0] : '0;

  spi_irq_sticky #(.W(IRQ_W)) u_state (
    .clk_i, .rst_ni, .set_i(cause | test_set), .clr_i(state_clr), .q_o(irq_state_q)
  );

  assign irq_err_o = irq_state_q[0] & irq_en_q[0];
  assign irq_evt_o = irq_state_q[1] & irq_en_q[1];

  // read mux; test register is write-only
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STATE:  reg_rdata_o[IRQ_W-1:0]    = irq_state_q;
      A_IRQ_EN: reg_rdata_o[IRQ_W-1:0]    = irq_en_q;
      A_ERR_EN: reg_rdata_o[ERR_EN_W-1:0] = err_en_q;
      A_ERR_ST: reg_rdata_o[ERR_W-1:0]    = err_status_q;
      A_EVT_EN: reg_rdata_o[EVT_W-1:0]    = evt_en_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [ERR_W-1:0]  err_pulse_i,
  input logic [EVT_W-1:0]  evt_level_i,
  input logic              irq_err_o,
  input logic              irq_evt_o,
  input logic [ERR_W-1:0]  err_status_q,
  input logic [ERR_EN_W-1:0] err_en_q,
  input logic [EVT_W-1:0]  evt_en_q,
  input logic [IRQ_W-1:0]  irq_state_q,
  input logic [IRQ_W-1:0]  irq_en_q
);
  // R3 and R10: a pulsed status bit is set on the next edge, clear or not
  assert_status_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_pulse_i) |=> ((err_status_q & $past(err_pulse_i)) == $past(err_pulse_i)));

  assert_err_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(err_status_q[ERR_EN_W-1:0] & err_en_q)) |=> irq_state_q[0]);

  assert_evt_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_level_i & evt_en_q)) |=> irq_state_q[1]);

  assert_test_force_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_TEST && reg_wdata_i[1]) |=> irq_state_q[1]);

  assert_pin_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_q[0] |-> !irq_err_o) and (!irq_en_q[1] |-> !irq_evt_o));

  assert_test_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_TEST) |-> (reg_rdata_o == '0));
endmodule

bind spi_irq_agg spi_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .err_pulse_i(err_pulse_i),
  .evt_level_i(evt_level_i), .irq_err_o(irq_err_o), .irq_evt_o(irq_evt_o),
  .err_status_q(err_status_q), .err_en_q(err_en_q), .evt_en_q(evt_en_q),
  .irq_state_q(irq_state_q), .irq_en_q(irq_en_q)
);

// File: tb/sim_spi_irq_agg.sv
`timescale 1ns/1ps
module sim_spi_irq_agg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [5:0]  err_pulse_i = '0;
  logic [5:0]  evt_level_i = '0;
  logic        irq_err_o, irq_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_irq_agg u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk_i);
    err_pulse_i = m;
    @(negedge clk_i);
    err_pulse_i = '0;
  endtask

  task automatic clean();
    wr(3'd4, 32'h3F);
    wr(3'd0, 32'h3);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 state", v, 0);
    rd(3'd1, v); chk("R1 irq_en", v, 0);
    rd(3'd3, v); chk("R1 err_en", v, 32'h1F);
    rd(3'd4, v); chk("R1 err_st", v, 0);
    rd(3'd5, v); chk("R1 evt_en", v, 0);
    chk("R1 pins", {30'd0, irq_evt_o, irq_err_o}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(3'd5, 32'hFFFF_FFEA); rd(3'd5, v); chk("R2 evt_en width", v, 32'h2A);
    wr(3'd3, 32'h0000_0025); rd(3'd3, v); chk("R2 err_en width", v, 32'h05);
    wr(3'd1, 32'h0000_0006); rd(3'd1, v); chk("R2 irq_en width", v, 32'h2);
    rd(3'd6, v); chk("R2 unmapped 6", v, 0);
    rd(3'd7, v); chk("R2 unmapped 7", v, 0);
    wr(3'd5, 0); wr(3'd3, 32'h1F); wr(3'd1, 0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    pulse(6'h04); rd(3'd4, v); chk("R3 underflow bit 2", v, 32'h04);
    pulse(6'h01); rd(3'd4, v); chk("R3 sticky busy bit 0", v, 32'h05);
    wr(3'd4, 32'h04); rd(3'd4, v); chk("R3 w1c", v, 32'h01);
    rd(3'd0, v); chk("R4 error state set", v, 32'h1);
    chk("R8 masked error pin", {31'd0, irq_err_o}, 0);
    wr(3'd1, 32'h1);
    chk("R8 error pin", {31'd0, irq_err_o}, 1);
    clean();
    rd(3'd0, v); chk("R7 cleared state", v, 0);
    chk("R8 error pin low", {31'd0, irq_err_o}, 0);
    wr(3'd1, 0);
  endtask

  task automatic t_err_mask();
    logic [31:0] v;
    pulse(6'h20); @(negedge clk_i);
    rd(3'd4, v); chk("R3 access bit 5", v, 32'h20);
    rd(3'd0, v); chk("R4 access no interrupt", v, 0);
    wr(3'd4, 32'h20);
    wr(3'd3, 32'h1D);
    pulse(6'h02); @(negedge clk_i);
    rd(3'd4, v); chk("R3 overflow bit 1", v, 32'h02);
    rd(3'd0, v); chk("R4 disabled cause", v, 0);
    wr(3'd3, 32'h1F);
    @(negedge clk_i);
    rd(3'd0, v); chk("R4 enabled later", v, 32'h1);
    clean();
  endtask

  task automatic t_evt();
    logic [31:0] v;
    @(negedge clk_i); evt_level_i = 6'h01;
    @(negedge clk_i); @(negedge clk_i);
    rd(3'd0, v); chk("R5 disabled rx full", v, 0);
    wr(3'd5, 32'h10);
    @(negedge clk_i); evt_level_i = 6'h10;
    @(negedge clk_i);
    rd(3'd0, v); chk("R5 ready event", v, 32'h2);
    wr(3'd1, 32'h2);
    chk("R8 event pin", {31'd0, irq_evt_o}, 1);
    wr(3'd0, 32'h2); rd(3'd0, v); chk("R7 clear with cause held", v, 32'h2);
    @(negedge clk_i); evt_level_i = 6'h00;
    wr(3'd0, 32'h2); rd(3'd0, v); chk("R7 clear after drop", v, 0);
    chk("R8 event pin low", {31'd0, irq_evt_o}, 0);
    wr(3'd1, 0); wr(3'd5, 0);
  endtask

  task automatic t_test();
    logic [31:0] v;
    wr(3'd2, 32'h3);
    rd(3'd0, v); chk("R6 test force both", v, 32'h3);
    rd(3'd2, v); chk("R9 test reads zero", v, 0);
    wr(3'd0, 32'h3);
    repeat (3) @(negedge clk_i);
    rd(3'd0, v); chk("R6 force one shot", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(6'h08);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 32'h08; err_pulse_i = 6'h08;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0; err_pulse_i = '0;
    rd(3'd4, v); chk("R10 set wins over clear", v, 32'h08);
    clean();
    rd(3'd4, v); chk("R3 cleared after collision", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_map();
    t_err();
    t_err_mask();
    t_evt();
    t_test();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule